// File: doc/BRIEF.md
# Byte-Serial Debug Packet Bridge

This block joins an 8-bit byte channel to a wide debug packet path and works in both directions. On the receive side, accepted bytes enter the low end of a packet-wide shift register. Each new byte pushes the earlier ones up by one byte position. Once a set number of bytes has been gathered, the register is offered as one packet to a valid/ready sink. Byte intake pauses until the sink takes the packet.

On the transmit side, a wide word held by a valid/ready source is sent out one byte at a time, lowest byte first, on an 8-bit valid/ready output. The source word is acknowledged in the same cycle that its last byte is accepted downstream. The two directions are independent. They use different byte counts: eight bytes per inbound packet and six per outbound word by default.

Top module: `dbg_byte_bridge`

## Requirements
- R1: While `rst_n` is low, and up to the first rising clock edge after it goes high, `byte_in_ready`, `pkt_valid`, `byte_out_valid` and `word_ack` are all low. Reset clears both byte counters and the packet register.
- R2: A byte is accepted only on a rising edge where `byte_in_valid` and `byte_in_ready` are both high. It enters `pkt_data[7:0]`, every earlier bit moves up by 8 positions, and the top 8 bits are discarded.
- R3: `byte_in_ready` is high, outside reset, while fewer than IN_BYTES bytes are held. It is low once IN_BYTES bytes are held, and bytes offered then have no effect.
- R4: Once IN_BYTES bytes are held, `pkt_valid` is high and `pkt_data` is stable until `pkt_ready` is sampled high. On that edge the count returns to zero, so in the next cycle `pkt_valid` is low and `byte_in_ready` is high.
- R5: After a packet is taken, the register keeps its contents. With PKT_W above 8*IN_BYTES, the bits above the newest IN_BYTES bytes hold the bytes shifted in just before them.
- R6: Outside reset, `byte_out_valid` follows `word_valid`. `byte_out_data` equals `word_data[8k+7:8k]`, where k (0 to OUT_BYTES-1) is the number of bytes of the current word already accepted. Word bits at or above 8*OUT_BYTES are never sent.
- R7: k advances by one only on an edge where `byte_out_valid` and `byte_out_ready` are both high. While downstream stalls, a held word keeps `byte_out_data` unchanged.
- R8: `word_ack` is high exactly when `byte_out_valid` and `byte_out_ready` are both high with k = OUT_BYTES-1. On that edge k returns to 0, so the next word starts at its low byte.
- R9: `byte_out_ready` has no effect while `byte_out_valid` is low. The first byte of the next word is its low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| byte_in_valid | input | 1 | Inbound byte present |
| byte_in_data | input | 8 | Inbound byte |
| byte_in_ready | output | 1 | Bridge can take a byte |
| pkt_valid | output | 1 | Assembled packet offered |
| pkt_ready | input | 1 | Sink takes the packet |
| pkt_data | output | PKT_W | Packet shift register |
| word_valid | input | 1 | Outbound word present |
| word_data | input | WORD_W | Outbound word |
| word_ack | output | 1 | Word fully sent, source may advance |
| byte_out_valid | output | 1 | Outbound byte present |
| byte_out_ready | input | 1 | Downstream takes the byte |
| byte_out_data | output | 8 | Outbound byte |

## Verification
The bench builds the bridge with a 72-bit packet and a 56-bit word while keeping eight inbound and six outbound bytes. With these widths, the top packet byte is visibly carried over from the previous packet (R5), and the top word byte must never appear on the byte output (R6). Directed sequences cover bytes offered while a packet waits, stalls in the middle of a word, ready toggling with no word present, and a reset in the middle of traffic. A long random phase then drives both directions at once against the behavioural model.

// File: rtl/dbb_pkg.sv
// Package: shared constants and helpers for the debug byte bridge.
// Assumes: byte lanes are 8 bits wide everywhere in the bridge.
package dbb_pkg;
    localparam int BYTE_W = 8;

    // Bits needed to count from 0 up to and including n.
    function automatic int count_bits(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

    // Bits needed to index n items (at least one bit).
    function automatic int index_bits(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/dbb_byte_packer.sv
// Module: dbb_byte_packer
// Gathers IN_BYTES bytes into a PKT_W-bit shift register (newest byte at
// the bottom) and offers the result on a valid/ready packet port.
// Assumes: PKT_W >= 8*IN_BYTES; `run` is low during and just after reset.
module dbb_byte_packer
    import dbb_pkg::*;
#(
    parameter int PKT_W    = 64,
    parameter int IN_BYTES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             pkt_valid,
    input  logic             pkt_ready,
    output logic [PKT_W-1:0] pkt_data
);
    localparam int CW = count_bits(IN_BYTES);
    localparam logic [CW-1:0] FULL = CW'(IN_BYTES);

    logic [CW-1:0]    fill_q;
    logic [PKT_W-1:0] shreg_q;
    logic             take;
    logic             handoff;

    assign in_ready  = run && (fill_q < FULL);
    assign pkt_valid = run && (fill_q == FULL);
    assign take      = in_valid && in_ready;
    assign handoff   = pkt_valid && pkt_ready;
    assign pkt_data  = shreg_q;

    // Count bytes held; clear when the sink takes the packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else if (take) begin
            fill_q <= fill_q + CW'(1);
        end else if (handoff) begin
            fill_q <= '0;
        end
    end

    // Shift each accepted byte into the low end of the packet register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
        end else if (take) begin
            shreg_q <= {shreg_q[PKT_W-BYTE_W-1:0], in_data};
        end
    end
endmodule

// File: rtl/dbb_word_slicer.sv
// Module: dbb_word_slicer
// Sends the low OUT_BYTES bytes of a held word, lowest first, and
// acknowledges the word together with its last byte.
// Assumes: WORD_W >= 8*OUT_BYTES; the source holds word_data until word_ack.
// USE_SHIFTER picks a barrel shift (1) or a byte-lane select (0).
module dbb_word_slicer
    import dbb_pkg::*;
#(
    parameter int WORD_W      = 48,
    parameter int OUT_BYTES   = 6,
    parameter bit USE_SHIFTER = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              word_ack,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data
);
    localparam int IW = index_bits(OUT_BYTES);
    localparam logic [IW-1:0] LAST = IW'(OUT_BYTES - 1);

    logic [IW-1:0] idx_q;
    logic          beat;
    logic          last_beat;

    assign out_valid = run && word_valid;
    assign beat      = out_valid && out_ready;
    assign last_beat = (idx_q == LAST);
    assign word_ack  = beat && last_beat;

    // Track which byte of the current word is on the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (beat) begin
            idx_q <= last_beat ? '0 : (idx_q + IW'(1));
        end
    end

    generate
        if (USE_SHIFTER) begin : g_shift
            logic [WORD_W-1:0] shifted;
            // Right shift by eight times the byte index.
            always_comb begin
                shifted = word_data >> {idx_q, 3'b000};
            end
            assign out_data = shifted[7:0];
        end else begin : g_lanes
            logic [7:0] lane [OUT_BYTES];
            for (genvar g = 0; g < OUT_BYTES; g++) begin : g_lane
                assign lane[g] = word_data[g*BYTE_W +: BYTE_W];
            end
            // OR-select the lane matching the byte index.
            always_comb begin
                out_data = '0;
                for (int k = 0; k < OUT_BYTES; k++) begin
                    if (idx_q == IW'(k)) out_data = out_data | lane[k];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/dbg_byte_bridge.sv
// Module: dbg_byte_bridge (top)
// Bridges an 8-bit byte channel to a wide debug packet path: a packer on
// the inbound side, a slicer on the outbound side, sharing clock and reset.
// Assumes: synchronous active-low reset; no request is raised until the
// first rising edge after reset is released.
module dbg_byte_bridge #(
    parameter int PKT_W       = 64,
    parameter int WORD_W      = 48,
    parameter int IN_BYTES    = 8,
    parameter int OUT_BYTES   = 6,
    parameter bit USE_SHIFTER = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_in_valid,
    input  logic [7:0]        byte_in_data,
    output logic              byte_in_ready,
    output logic              pkt_valid,
    input  logic              pkt_ready,
    output logic [PKT_W-1:0]  pkt_data,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              word_ack,
    output logic              byte_out_valid,
    input  logic              byte_out_ready,
    output logic [7:0]        byte_out_data
);
    logic run_q;

    // Enable both directions one edge after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= 1'b1;
    end

    dbb_byte_packer #(
        .PKT_W    (PKT_W),
        .IN_BYTES (IN_BYTES)
    ) u_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_q),
        .in_valid  (byte_in_valid),
        .in_data   (byte_in_data),
        .in_ready  (byte_in_ready),
        .pkt_valid (pkt_valid),
        .pkt_ready (pkt_ready),
        .pkt_data  (pkt_data)
    );

    dbb_word_slicer #(
        .WORD_W      (WORD_W),
        .OUT_BYTES   (OUT_BYTES),
        .USE_SHIFTER (USE_SHIFTER)
    ) u_slicer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run_q),
        .word_valid (word_valid),
        .word_data  (word_data),
        .word_ack   (word_ack),
        .out_valid  (byte_out_valid),
        .out_ready  (byte_out_ready),
        .out_data   (byte_out_data)
    );
endmodule

// File: rtl/dbb_bridge_chk.sv
// Module: dbb_bridge_chk
// Protocol checks on the bridge ports, bound into every dbg_byte_bridge.
module dbb_bridge_chk #(
    parameter int PKT_W  = 64,
    parameter int WORD_W = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              byte_in_valid,
    input logic [7:0]        byte_in_data,
    input logic              byte_in_ready,
    input logic              pkt_valid,
    input logic              pkt_ready,
    input logic [PKT_W-1:0]  pkt_data,
    input logic              word_valid,
    input logic [WORD_W-1:0] word_data,
    input logic              word_ack,
    input logic              byte_out_valid,
    input logic              byte_out_ready,
    input logic [7:0]        byte_out_data
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!pkt_valid && !byte_out_valid && !word_ack && !byte_in_ready));

    // R2
    shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_in_valid && byte_in_ready) |=>
            (pkt_data[7:0] == $past(byte_in_data) &&
             pkt_data[15:8] == $past(pkt_data[7:0])));

    // R4
    pkt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_data)));

    // R4
    pkt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_ready) |=> (!pkt_valid && byte_in_ready));

    // R7
    out_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_out_valid && !byte_out_ready) ##1 $stable(word_data)
            |-> $stable(byte_out_data));

    // R8
    ack_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_ack |-> (byte_out_valid && byte_out_ready));

    // R8
    ack_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_ack |=> (!byte_out_valid || byte_out_data == word_data[7:0]));
endmodule

bind dbg_byte_bridge dbb_bridge_chk #(
    .PKT_W  (PKT_W),
    .WORD_W (WORD_W)
) u_chk (.*);

// File: tb/dbg_byte_bridge_bench.sv
module dbg_byte_bridge_bench;
    localparam int PW = 72;
    localparam int WW = 56;
    localparam int NI = 8;
    localparam int NO = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          byte_in_valid;
    logic [7:0]    byte_in_data;
    logic          byte_in_ready;
    logic          pkt_valid;
    logic          pkt_ready;
    logic [PW-1:0] pkt_data;
    logic          word_valid;
    logic [WW-1:0] word_data;
    logic          word_ack;
    logic          byte_out_valid;
    logic          byte_out_ready;
    logic [7:0]    byte_out_data;

    always #5 clk = ~clk;

    dbg_byte_bridge #(
        .PKT_W(PW), .WORD_W(WW), .IN_BYTES(NI), .OUT_BYTES(NO), .USE_SHIFTER(1'b0)
    ) u_dbg_byte_bridge (
        .clk(clk), .rst_n(rst_n),
        .byte_in_valid(byte_in_valid), .byte_in_data(byte_in_data),
        .byte_in_ready(byte_in_ready),
        .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_data(pkt_data),
        .word_valid(word_valid), .word_data(word_data), .word_ack(word_ack),
        .byte_out_valid(byte_out_valid), .byte_out_ready(byte_out_ready),
        .byte_out_data(byte_out_data)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Behavioural reference state
    bit            m_run;
    int            m_icnt;
    int            m_ocnt;
    logic [PW-1:0] m_pkt;
    bit            m_word_done;

    always @(posedge clk) begin : ref_model
        bit rdy;
        bit bov;
        rdy = m_run && (m_icnt < NI);
        bov = m_run && word_valid;
        if (!rst_n) begin
            m_run = 0; m_icnt = 0; m_ocnt = 0; m_pkt = '0; m_word_done = 0;
        end else begin
            m_word_done = 0;
            if (byte_in_valid && rdy) begin
                m_pkt = {m_pkt[PW-9:0], byte_in_data};
                m_icnt++;
            end else if (m_run && m_icnt == NI && pkt_ready) begin
                m_icnt = 0;
            end
            if (bov && byte_out_ready) begin
                if (m_ocnt == NO - 1) begin m_ocnt = 0; m_word_done = 1; end
                else m_ocnt++;
            end
            m_run = 1;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [WW-1:0] sh;
        bit e_bov;
        sh    = word_data >> (8 * m_ocnt);
        e_bov = m_run && word_valid;
        if (!m_run) begin
            chk("R1", "byte_in_ready", byte_in_ready, 0);
            chk("R1", "pkt_valid", pkt_valid, 0);
            chk("R1", "byte_out_valid", byte_out_valid, 0);
            chk("R1", "word_ack", word_ack, 0);
        end
        chk("R3", "byte_in_ready", byte_in_ready, m_run && m_icnt < NI);
        chk("R4", "pkt_valid", pkt_valid, m_run && m_icnt == NI);
        chk("R2", "pkt_data", pkt_data, m_pkt);
        chk("R6", "byte_out_valid", byte_out_valid, e_bov);
        if (e_bov) chk("R7", "byte_out_data", byte_out_data, sh[7:0]);
        chk("R8", "word_ack", word_ack, e_bov && byte_out_ready && m_ocnt == NO - 1);
    endtask

    // One cycle: inputs already set at this negedge, check, then advance.
    task automatic settle_and_check();
        #1 compare_all();
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : stim
        logic [7:0] got[$];
        rst_n = 0; byte_in_valid = 0; byte_in_data = 0; pkt_ready = 0;
        word_valid = 1; word_data = 56'h77665544332211; byte_out_ready = 1;
        @(negedge clk);
        // R1: reset held with a word offered
        for (int i = 0; i < 3; i++) settle_and_check();
        rst_n = 1;
        #1 chk("R1", "byte_out_valid first cycle after release", byte_out_valid, 0);
        chk("R1", "pkt_data after reset", pkt_data, 0);
        @(negedge clk);
        word_valid = 0;

        // R2/R3: eight bytes, then extra bytes while the packet waits
        for (int i = 1; i <= NI; i++) begin
            byte_in_valid = 1; byte_in_data = 8'(i);
            settle_and_check();
        end
        byte_in_data = 8'hEE;
        settle_and_check();
        settle_and_check();
        #1 chk("R3", "extra bytes ignored", pkt_data, 72'h00_0102030405060708);
        chk("R4", "pkt_valid held", pkt_valid, 1);
        @(negedge clk);
        byte_in_valid = 0; pkt_ready = 1;
        settle_and_check();
        pkt_ready = 0;
        #1 chk("R4", "ready after handoff", byte_in_ready, 1);
        @(negedge clk);
        // R5: second packet with gaps
        for (int i = 0; i < NI; i++) begin
            byte_in_valid = 1; byte_in_data = 8'(8'h11 + i);
            settle_and_check();
            byte_in_valid = 0;
            settle_and_check();
        end
        #1 chk("R5", "carried top byte", pkt_data, 72'h08_1112131415161718);
        @(negedge clk);
        pkt_ready = 1;
        settle_and_check();
        pkt_ready = 0;

        // R9: ready toggles with no word
        for (int i = 0; i < 4; i++) begin
            byte_out_ready = i[0];
            settle_and_check();
        end
        // R6/R7/R8: directed word with stalls
        word_valid = 1; word_data = 56'hAABBCCDDEEFF11;
        #1 chk("R9", "first byte of word", byte_out_data, 8'h11);
        for (int i = 0; i < 40 && got.size() < NO; i++) begin
            byte_out_ready = (i % 3) != 1;
            #1 if (byte_out_valid && byte_out_ready) got.push_back(byte_out_data);
            compare_all();
            @(negedge clk);
        end
        word_valid = 0;
        chk("R6", "bytes sent", got.size(), NO);
        if (got.size() == NO) begin
            chk("R6", "byte0", got[0], 8'h11);
            chk("R6", "byte1", got[1], 8'hFF);
            chk("R6", "byte2", got[2], 8'hEE);
            chk("R6", "byte3", got[3], 8'hDD);
            chk("R6", "byte4", got[4], 8'hCC);
            chk("R8", "last byte", got[5], 8'hBB);
        end
        settle_and_check();

        // Random traffic in both directions
        for (int c = 0; c < 3000; c++) begin
            byte_in_valid  = ($urandom % 3) != 0;
            byte_in_data   = 8'($urandom);
            pkt_ready      = ($urandom % 4) == 0;
            byte_out_ready = ($urandom % 3) != 0;
            if (!word_valid || m_word_done) begin
                word_valid = ($urandom % 4) != 0;
                word_data  = {24'($urandom), 32'($urandom)};
            end
            settle_and_check();
        end

        // R1: reset in the middle of traffic
        rst_n = 0;
        settle_and_check();
        settle_and_check();
        rst_n = 1;
        settle_and_check();
        for (int c = 0; c < 200; c++) begin
            byte_in_valid  = ($urandom % 2) != 0;
            byte_in_data   = 8'($urandom);
            pkt_ready      = ($urandom % 2) == 0;
            byte_out_ready = ($urandom % 2) != 0;
            if (!word_valid || m_word_done) begin
                word_valid = 1;
                word_data  = {24'($urandom), 32'($urandom)};
            end
            settle_and_check();
        end
        finish_run();
    end
endmodule